// File: doc/BRIEF.md
# On-Chip Memory Security Splitter

This block sits in front of one on-chip static memory (SRAM or ROM of at most 2 MB) and divides it into two parts at one programmable boundary. Addresses below the boundary form the secure part; addresses at or above it form the non-secure part. Each request carries an address, a read/write strobe and a security attribute. A secure request may reach any address. A non-secure request may reach only the upper part.

Permitted requests go straight through to the memory port in the same cycle. A non-secure request that targets the secure part never selects the memory. Its address and write data are forced to zero on the memory side, and a one-cycle error pulse follows on the next cycle. The boundary is held as a count of 4 KB pages. It is loaded from a control input only when a secure-write qualifier is high.

Top module: `ocm_split_guard`

## Requirements
- R1: After reset the boundary is 512 pages, so the whole memory is secure and every non-secure request is blocked.
- R2: A secure request (req_nonsec_i=0) with req_valid_i=1 asserts mem_cs_o in the same cycle, with mem_addr_o equal to req_addr_i, mem_we_o equal to req_write_i and mem_wdata_o equal to req_wdata_i, whatever the boundary.
- R3: A non-secure request (req_nonsec_i=1) whose page index req_addr_i[20:12] is below the boundary keeps mem_cs_o and mem_we_o low, and raises err_o on the following cycle.
- R4: A non-secure request whose page index is at or above the boundary is passed to the memory as in R2. The first byte of the boundary page is non-secure and the byte just below it is secure.
- R5: With a boundary of 0 the whole memory is non-secure and no non-secure request is blocked.
- R6: With a boundary of 512 or more (up to 1023 in the 10-bit field) the whole memory is secure.
- R7: cfg_bound_i is loaded only on a clock edge where cfg_we_i=1. A request in the same cycle as the load is judged against the old boundary, and the next cycle uses the new one.
- R8: err_o is high only on the cycle after a blocked request. It lasts one cycle for each blocked request, and it is low after idle or permitted cycles. mem_cs_o is low whenever req_valid_i=0.
- R9: During a blocked request, mem_addr_o and mem_wdata_o are driven to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Secure-write qualifier for the boundary |
| cfg_bound_i | input | 10 | New boundary in 4 KB pages |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_nonsec_i | input | 1 | 1 = non-secure request |
| req_addr_i | input | 21 | Byte address |
| req_wdata_i | input | 32 | Write data |
| mem_cs_o | output | 1 | Memory chip select |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 21 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| err_o | output | 1 | Blocked-request pulse, one cycle after the request |

## Verification
The hardest case to reach is a boundary load and a non-secure request in the same cycle. The request must see the old boundary, and the request on the very next cycle must see the new one. The stimulus targets the boundary page directly in that pair of cycles. Directed accesses hit the first byte of the boundary page and the byte just below it, and the extreme boundaries 0, 511, 512 and 1023. A random phase then mixes boundary loads, requests with the qualifier low, and back-to-back blocked requests. Each cycle's expected error is queued for the monitor to compare one cycle later.

// File: rtl/ocm_split_pkg.sv
package ocm_split_pkg;

  typedef struct packed {
    logic valid;
    logic write;
    logic nonsec;
  } req_attr_t;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_PASS  = 2'd1,
    ACC_BLOCK = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/ocm_bound_reg.sv
module ocm_bound_reg #(
  parameter int BND_W       = 10,
  parameter int RESET_BOUND = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BND_W-1:0] val_i,
  output logic [BND_W-1:0] bound_o
);

  localparam logic [BND_W-1:0] RST_VAL = BND_W'(RESET_BOUND);

  logic [BND_W-1:0] bound_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bound_q <= RST_VAL;
    else if (we_i)  bound_q <= val_i;
  end

  assign bound_o = bound_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bound_q));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> bound_q == $past(val_i));

endmodule

// File: rtl/ocm_region_decode.sv
module ocm_region_decode
  import ocm_split_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int BND_W  = PAGE_W + 1
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [BND_W-1:0]  bound_i,
  input  req_attr_t         attr_i,
  output logic              in_secure_o,
  output acc_kind_e         kind_o
);

  // zero-extended page index vs. page-count boundary: below = secure part
  assign in_secure_o = {1'b0, page_i} < bound_i;

  always_comb begin
    if (!attr_i.valid)                     kind_o = ACC_IDLE;
    else if (attr_i.nonsec && in_secure_o) kind_o = ACC_BLOCK;
    else                                   kind_o = ACC_PASS;
  end

endmodule

// File: rtl/ocm_access_gate.sv
module ocm_access_gate
  import ocm_split_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int DATA_W       = 32,
  parameter bit MASK_BLOCKED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_cs_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              err_o
);

  logic pass, block, err_q;

  assign pass     = (kind_i == ACC_PASS);
  assign block    = (kind_i == ACC_BLOCK);
  assign mem_cs_o = pass;
  assign mem_we_o = pass & write_i;

  generate
    if (MASK_BLOCKED) begin : g_mask
      assign mem_addr_o  = block ? '0 : addr_i;
      assign mem_wdata_o = block ? '0 : wdata_i;
    end else begin : g_thru
      assign mem_addr_o  = addr_i;
      assign mem_wdata_o = wdata_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= block;
  end

  assign err_o = err_q;

  p_block_no_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block |-> !mem_cs_o && !mem_we_o);

  p_err_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block |=> err_o);

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !block |=> !err_o);

endmodule

// File: rtl/ocm_split_guard.sv
module ocm_split_guard
  import ocm_split_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int DATA_W       = 32,
  parameter int PAGE_SHIFT   = 12,
  parameter int RESET_BOUND  = 1 << (ADDR_W - PAGE_SHIFT),
  parameter bit MASK_BLOCKED = 1'b1,
  localparam int PAGE_W      = ADDR_W - PAGE_SHIFT,
  localparam int BND_W       = PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BND_W-1:0]  cfg_bound_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_nonsec_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              mem_cs_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              err_o
);

  localparam int PAGES = 1 << PAGE_W;

  logic [BND_W-1:0] bound;
  logic             in_secure;
  req_attr_t        attr;
  acc_kind_e        kind;

  assign attr = '{valid: req_valid_i, write: req_write_i, nonsec: req_nonsec_i};

  ocm_bound_reg #(
    .BND_W       (BND_W),
    .RESET_BOUND (RESET_BOUND)
  ) u_bound (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .val_i   (cfg_bound_i),
    .bound_o (bound)
  );

  ocm_region_decode #(
    .PAGE_W (PAGE_W),
    .BND_W  (BND_W)
  ) u_decode (
    .page_i      (req_addr_i[ADDR_W-1:PAGE_SHIFT]),
    .bound_i     (bound),
    .attr_i      (attr),
    .in_secure_o (in_secure),
    .kind_o      (kind)
  );

  ocm_access_gate #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .MASK_BLOCKED (MASK_BLOCKED)
  ) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kind_i      (kind),
    .write_i     (req_write_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .mem_cs_o    (mem_cs_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .err_o       (err_o)
  );

  p_secure_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_nonsec_i |-> mem_cs_o && mem_addr_o == req_addr_i);

  p_idle_no_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !mem_cs_o);

  p_zero_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound == '0 && req_valid_i |-> mem_cs_o);

  p_full_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound >= BND_W'(PAGES) && req_valid_i && req_nonsec_i |-> !mem_cs_o);

endmodule

// File: tb/ocm_split_guard_test.sv
module ocm_split_guard_test;

  localparam int AW = 21;
  localparam int DW = 32;
  localparam int BW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [BW-1:0] cfg_bound_i = '0;
  logic          req_valid_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic          req_nonsec_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          mem_cs_o, mem_we_o, err_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  always #5 clk = ~clk;

  ocm_split_guard uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_bound_i(cfg_bound_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_nonsec_i(req_nonsec_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .mem_cs_o(mem_cs_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .err_o(err_o)
  );

  typedef struct {
    logic  err;
    string tag;
  } exp_t;

  exp_t          exp_q[$];
  int            nchk = 0;
  int            nfail = 0;
  bit            done = 0;
  logic [BW-1:0] model_bound = 10'd512;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, queue the error expectation
  task automatic step(input logic v, input logic [AW-1:0] a, input logic wr, input logic ns,
                      input logic we, input logic [BW-1:0] bv, input string tag);
    logic [DW-1:0] wd;
    logic          sec, blk;
    @(negedge clk);
    wd = $urandom;
    req_valid_i = v; req_addr_i = a; req_write_i = wr; req_nonsec_i = ns;
    req_wdata_i = wd; cfg_we_i = we; cfg_bound_i = bv;
    #1;
    sec = {1'b0, a[20:12]} < model_bound;
    blk = v && ns && sec;
    check(mem_cs_o, v && !blk, {tag, " cs"});
    if (v && !blk) begin
      check(mem_addr_o, a, {tag, " addr"});
      check(mem_we_o, wr, {tag, " we"});
      check(mem_wdata_o, wd, {tag, " wdata"});
    end else begin
      check(mem_we_o, 0, {tag, " we"});
    end
    if (blk) begin
      check(mem_addr_o, 0, {tag, " R9 addr mask"});
      check(mem_wdata_o, 0, {tag, " R9 wdata mask"});
    end
    exp_q.push_back('{err: blk, tag: tag});
    if (we) model_bound = bv;
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic wr, input logic ns, input string tag);
    step(1'b1, a, wr, ns, 1'b0, 10'h0, tag);
  endtask

  task automatic set_bound(input logic [BW-1:0] bv, input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, bv, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 10'h0, tag);
  endtask

  // monitor: error for the request of cycle k is visible just after edge k
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(err_o, e.err, {e.tag, " err"});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(mem_cs_o, 0, "R8 reset cs");
    check(err_o, 0, "R8 reset err");
    @(negedge clk);
    rst_ni = 1'b1;

    acc(21'h1FFFFF, 0, 1, "R1 nonsec top after reset");
    acc(21'h000000, 1, 1, "R1 nonsec bottom after reset");
    acc(21'h000000, 1, 0, "R2 secure write bottom");
    acc(21'h1ABCDE, 0, 0, "R2 secure read high");
    idle("R8 idle after pass");

    set_bound(10'd16, "R7 load 16");
    acc(21'h00FFFF, 0, 1, "R3 nonsec last secure byte");
    acc(21'h010000, 1, 1, "R4 nonsec boundary first byte");
    acc(21'h010001, 0, 1, "R4 nonsec above boundary");
    acc(21'h00F000, 0, 0, "R2 secure into secure part");
    acc(21'h000100, 1, 1, "R3 back-to-back blocked 1");
    acc(21'h000200, 0, 1, "R3 back-to-back blocked 2");
    idle("R8 pulse ends");

    // qualifier low: boundary must stay at 16
    step(1'b1, 21'h010000, 0, 1, 1'b0, 10'd0, "R7 we low keep pass");
    step(1'b1, 21'h00FFFF, 0, 1, 1'b0, 10'd0, "R7 we low keep block");
    // same-cycle load to 32: old boundary applies, new one next cycle
    step(1'b1, 21'h010000, 0, 1, 1'b1, 10'd32, "R7 same-cycle old bound");
    acc(21'h010000, 0, 1, "R7 next cycle new bound");
    acc(21'h020000, 0, 1, "R4 new boundary page");

    set_bound(10'd0, "R5 load 0");
    acc(21'h000000, 1, 1, "R5 nonsec bottom");
    acc(21'h1FFFFF, 0, 1, "R5 nonsec top");

    set_bound(10'd512, "R6 load 512");
    acc(21'h1FF000, 0, 1, "R6 nonsec last page 512");
    set_bound(10'd1023, "R6 load 1023");
    acc(21'h1FFFFF, 1, 1, "R6 nonsec top 1023");
    acc(21'h1FFFFF, 1, 0, "R6 secure top 1023");
    set_bound(10'd511, "R4 load 511");
    acc(21'h1FF000, 0, 1, "R4 last page open");
    acc(21'h1FEFFF, 0, 1, "R3 below last page");

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic          we;
      a  = $urandom;
      we = ($urandom % 8) == 0;
      step($urandom % 4 != 0, a, $urandom % 2, $urandom % 2, we,
           BW'($urandom % 600), "R3/R4 random");
    end
    idle("R8 final idle");
    idle("R8 drain");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule